// File: doc/BRIEF.md
# Serial BCD to Excess-3 Converter

This block converts one decimal digit at a time from BCD to Excess-3 while the digit is still arriving. The digit comes in on a single serial line, least significant bit first, one bit per clock. The matching Excess-3 bit is produced on a single serial output during the same clock cycle. The conversion is done by a seven-state Mealy machine. Its transitions carry the add-three across the four bit times, so the block needs no adder and no shift register. After the fourth bit the machine is back in its starting state, and the next digit can follow without a gap.

There is one invalid path. If the three low bits of a digit are 101, 110 or 111 and the fourth bit is 1, the machine drives a 0, raises an error flag for that one cycle and restarts. A parameter selects a registered copy of both outputs, delayed by one clock, for use where a glitch-free output is wanted.

Top module: `serial_xs3_conv`

## Requirements
- R1: With `REG_OUT`=0, `z_o` follows `x_i` and the current state within the same cycle, with no clock in between. On the first bit of a digit, `z_o` is the inverse of `x_i`.
- R2: The digit 0000, sent as 0,0,0,0, produces `z_o` = 1,1,0,0 over its four cycles.
- R3: The digit 0111, sent as 1,1,1,0, produces `z_o` = 0,1,0,1 over its four cycles.
- R4: For every digit value from 0 to 9, the `z_o` bit in bit time i (i = 0 to 3) equals bit i of the digit plus three, and `err_o` stays 0.
- R5: After four bit times the machine is back in its initial state, so digits sent back to back with no idle cycle each convert correctly.
- R6: Take a digit whose bits 0 to 2 are 101, 110 or 111 (as 4-bit values, 0101, 0110 or 0111), and whose fourth bit is 1. In that fourth cycle `z_o`=0 and `err_o`=1. In every other cycle `err_o`=0, and the next digit starts from the initial state.
- R7: The invalid codes 10, 11 and 12 follow the same rule as R4: `z_o` bit i equals bit i of the value plus three, and `err_o` is 0.
- R8: `rst` is synchronous and overrides `x_i`. While it is high, `z_o` and `err_o` are 0. The first bit after it is released is treated as bit 0 of a new digit.
- R9: With `REG_OUT`=1, `z_o` and `err_o` equal the values the `REG_OUT`=0 variant showed one clock earlier. They are 0 in the cycle after a clock edge at which `rst` was high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the state advances on the rising edge |
| rst | input | 1 | Synchronous active-high reset to the initial state |
| x_i | input | 1 | Serial BCD bit, least significant bit first |
| z_o | output | 1 | Serial Excess-3 bit |
| err_o | output | 1 | One-cycle flag for the invalid fourth bit |

## Verification
The bench builds two copies side by side, one with `REG_OUT`=0 and one with `REG_OUT`=1, and drives both from the same serial stream. The combinational copy shows that the same-cycle dependence of `z_o` on `x_i` works, including a change of `x_i` within one cycle. The registered copy is compared against the one-cycle-delayed model, so the delay and the clearing by reset are checked on every clock. Both copies see all sixteen 4-bit codes back to back, which exercises the invalid path and the restart after it.

// File: rtl/xs3_pkg.sv
package xs3_pkg;

   // State codes of the serial add-three machine
   typedef enum logic [2:0] {
      ST_0 = 3'b000,
      ST_1 = 3'b001,
      ST_2 = 3'b011,
      ST_3 = 3'b110,
      ST_4 = 3'b100,
      ST_5 = 3'b111,
      ST_6 = 3'b101
   } xs3_state_t;

   localparam int unsigned STATE_W   = 3;
   localparam logic [STATE_W-1:0] CODE_SPARE = 3'b010;

endpackage

// File: rtl/xs3_next_logic.sv
module xs3_next_logic
   import xs3_pkg::*;
(
   input  xs3_state_t st_i,
   input  logic       x_i,
   output xs3_state_t nxt_o,
   output logic       z_o,
   output logic       err_o
);

   always_comb begin
      nxt_o = ST_0;
      z_o   = 1'b0;
      err_o = 1'b0;
      case (st_i)
         ST_0: begin
            nxt_o = x_i ? ST_2 : ST_1;
            z_o   = ~x_i;
         end
         ST_1: begin
            nxt_o = x_i ? ST_4 : ST_3;
            z_o   = ~x_i;
         end
         ST_2: begin
            nxt_o = ST_4;
            z_o   = x_i;
         end
         ST_3: begin
            nxt_o = ST_5;
            z_o   = x_i;
         end
         ST_4: begin
            nxt_o = x_i ? ST_6 : ST_5;
            z_o   = ~x_i;
         end
         ST_5: begin
            nxt_o = ST_0;
            z_o   = x_i;
         end
         ST_6: begin
            nxt_o = ST_0;
            z_o   = ~x_i;
            err_o = x_i;
         end
         default: begin
            nxt_o = ST_0;
         end
      endcase
   end

endmodule

// File: rtl/xs3_state_reg.sv
module xs3_state_reg
   import xs3_pkg::*;
(
   input  logic       clk,
   input  logic       rst,
   input  xs3_state_t nxt_i,
   output xs3_state_t st_o
);

   always_ff @(posedge clk) begin
      if (rst) st_o <= ST_0;
      else     st_o <= nxt_i;
   end

   // R8: the cycle after a reset edge starts from the initial state
   p_reset_start_r8: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> st_o == ST_0);

   // R5: the spare code is never entered
   p_no_spare_r5: assert property (@(posedge clk) disable iff (rst)
      st_o != CODE_SPARE);

endmodule

// File: rtl/xs3_out_stage.sv
module xs3_out_stage #(
   parameter int unsigned REG_OUT = 0
) (
   input  logic clk,
   input  logic rst,
   input  logic z_c_i,
   input  logic err_c_i,
   output logic z_o,
   output logic err_o
);

   generate
      if (REG_OUT == 1) begin : g_reg
         always_ff @(posedge clk) begin
            if (rst) begin
               z_o   <= 1'b0;
               err_o <= 1'b0;
            end else begin
               z_o   <= z_c_i;
               err_o <= err_c_i;
            end
         end

         // R9: registered copy trails the combinational value by one clock
         p_delay_r9: assert property (@(posedge clk) disable iff (rst)
            !$past(rst) |-> (z_o == $past(z_c_i)) && (err_o == $past(err_c_i)));
      end else if (REG_OUT == 0) begin : g_comb
         assign z_o   = z_c_i;
         assign err_o = err_c_i;
      end else begin : g_bad
         $error("xs3_out_stage: REG_OUT must be 0 or 1");
      end
   endgenerate

endmodule

// File: rtl/serial_xs3_conv.sv
module serial_xs3_conv
   import xs3_pkg::*;
#(
   parameter int unsigned REG_OUT = 0
) (
   input  logic clk,
   input  logic rst,
   input  logic x_i,
   output logic z_o,
   output logic err_o
);

   xs3_state_t st;
   xs3_state_t nxt;
   logic       z_n;
   logic       err_n;
   logic       z_c;
   logic       err_c;

   xs3_next_logic u_next (
      .st_i  (st),
      .x_i   (x_i),
      .nxt_o (nxt),
      .z_o   (z_n),
      .err_o (err_n)
   );

   xs3_state_reg u_state (
      .clk   (clk),
      .rst   (rst),
      .nxt_i (nxt),
      .st_o  (st)
   );

   // reset silences both outputs
   assign z_c   = z_n & ~rst;
   assign err_c = err_n & ~rst;

   xs3_out_stage #(.REG_OUT(REG_OUT)) u_out (
      .clk     (clk),
      .rst     (rst),
      .z_c_i   (z_c),
      .err_c_i (err_c),
      .z_o     (z_o),
      .err_o   (err_o)
   );

   // R1: from the initial state the next state reflects the first bit
   p_first_bit_r1: assert property (@(posedge clk) disable iff (rst)
      (st == ST_0) |=> (st == ST_1 || st == ST_2));

   // R5: the fourth bit always returns to the initial state
   p_digit_end_r5: assert property (@(posedge clk) disable iff (rst)
      (st == ST_5 || st == ST_6) |=> st == ST_0);

   // R6: an error cycle is followed by a fresh digit
   p_err_restart_r6: assert property (@(posedge clk) disable iff (rst)
      err_c |=> st == ST_0);

   // R6: an error cycle drives a zero
   p_err_zero_r6: assert property (@(posedge clk) disable iff (rst)
      err_c |-> !z_c);

endmodule

// File: tb/tb_serial_xs3_conv.sv
module tb_serial_xs3_conv;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic x   = 1'b0;
   logic z_c, e_c, z_q, e_q;

   int n_tests = 0;
   int n_fail  = 0;

   // model state
   int   idx = 0;
   int   acc = 0;
   logic qz  = 1'b0;
   logic qe  = 1'b0;

   always #4 clk = ~clk;

   serial_xs3_conv #(.REG_OUT(0)) dut (
      .clk(clk), .rst(rst), .x_i(x), .z_o(z_c), .err_o(e_c));

   serial_xs3_conv #(.REG_OUT(1)) dut_q (
      .clk(clk), .rst(rst), .x_i(x), .z_o(z_q), .err_o(e_q));

   task automatic check(input logic act, input logic exp, input string tag);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic step(input logic xb, input logic rb, input string tag);
      logic ez, ee;
      int   low;
      @(negedge clk);
      x   = xb;
      rst = rb;
      #2;
      low = acc | (int'(xb) << idx);
      if (rb) begin
         ez = 1'b0; ee = 1'b0;
      end else if (idx == 3 && xb && acc[2] && acc[1:0] != 0) begin
         ez = 1'b0; ee = 1'b1;
      end else begin
         ez = 1'(((low + 3) >> idx) & 1);
         ee = 1'b0;
      end
      check(z_c, ez, tag);
      check(e_c, ee, tag);
      check(z_q, qz, "R9");
      check(e_q, qe, "R9");
      @(posedge clk);
      if (rb || idx == 3) begin
         idx = 0; acc = 0;
      end else begin
         acc = low; idx++;
      end
      qz = ez;
      qe = ee;
   endtask

   task automatic send_digit(input int d, input string tag);
      for (int i = 0; i < 4; i++) step(1'((d >> i) & 1), 1'b0, tag);
   endtask

   initial begin
      #(200000 * 8);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      // R8: outputs quiet while reset is held, x ignored
      step(1'b1, 1'b1, "R8");
      step(1'b0, 1'b1, "R8");
      step(1'b1, 1'b1, "R8");

      // R2 and R3: the two worked digits
      send_digit(0, "R2");
      send_digit(7, "R3");

      // R1: output follows x within one cycle in the initial state
      @(negedge clk);
      x = 1'b0; #1;
      check(z_c, 1'b1, "R1");
      x = 1'b1; #1;
      check(z_c, 1'b0, "R1");
      x = 1'b0; #1;
      check(z_c, 1'b1, "R1");
      // finish this cycle as bit 0 = 0 of a digit; model tracks it
      @(posedge clk);
      idx = 1; acc = 0; qz = 1'b1; qe = 1'b0;
      for (int i = 1; i < 4; i++) step(1'b0, 1'b0, "R1");

      // R4, R5, R6, R7: all sixteen codes back to back
      for (int d = 0; d < 16; d++) begin
         if (d <= 9)       send_digit(d, "R4_R5");
         else if (d <= 12) send_digit(d, "R7");
         else              send_digit(d, "R6");
      end
      // R6: digit after an invalid one starts clean
      send_digit(3, "R6");

      // R8: reset mid-digit, then a fresh digit
      step(1'b1, 1'b0, "R8");
      step(1'b1, 1'b0, "R8");
      step(1'b1, 1'b1, "R8");
      send_digit(9, "R8");
      send_digit(5, "R5");

      @(negedge clk);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule